// File: doc/BRIEF.md
# Half-Rate Paired Sample Output Stage

This block takes a stream of converter sample codes at full rate, one code per rising edge of the sample clock. It hands them on at half rate as pairs of consecutive samples on two parallel ports. A "newer" port always carries the later sample of the pair and an "older" port the earlier one. A data-ready clock at half the sample rate goes with the ports, and both ports are updated only on its rising edge. The pairing is fixed against reset, so the newest sample lands on the newer port whatever the phase of the data-ready clock.

Each path has a fixed depth. A code captured on sample-clock edge k shows up on the newer port right after edge k+5, and on the older port right after edge k+6. When the input is offset binary, a build parameter turns it into two's complement by flipping the top bit. When the input is already two's complement, the parameter passes it through unchanged. A flag comes high at the first update whose older sample was captured after reset, and it stays high until the next reset.

Top module: `sdm_pair_demux`

## Requirements
- R1: With the offset-binary coding selected, every port value is the captured code with its most significant bit inverted (input 0x00 gives 0x20, input 0x3F gives 0x1F). Each port is 6 bits wide.
- R2: With the two's-complement coding selected, the captured code reaches the ports unchanged.
- R3: At each update, the newer port holds the code captured 5 sample-clock edges earlier. A stage that has not yet received a sample since reset gives 0.
- R4: At each update, the older port holds the code captured 6 sample-clock edges earlier.
- R5: The two ports always carry consecutive samples, and the older port carries the earlier one. For an incrementing input, the newer value minus the older value is 1, modulo 64.
- R6: The data-ready output is low after reset, rises on the first sample-clock edge after reset is released, and then inverts on every sample-clock edge.
- R7: The two ports change only on the sample-clock edge where data-ready rises. On the other edges they hold their values.
- R8: While the synchronous active-high reset is asserted, the next edge clears both ports, data-ready and the valid flag, and it empties the capture pipeline.
- R9: The valid flag stays low until the data-ready rise on the 7th edge after reset release, which is the first update whose older sample was captured after reset. From then on it stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Full-rate sample clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| smp_in | input | 6 | Converter code, captured on every rising edge |
| dready | output | 1 | Half-rate data-ready clock, 50% duty |
| new_out | output | 6 | Newer sample of the pair |
| old_out | output | 6 | Older sample of the pair |
| pair_valid | output | 1 | High once the pipeline holds a full post-reset pair |

## Verification
The bench builds two copies side by side, both with the default depth of 5 for the newer path and 6 for the older path. One copy is set for offset-binary input and the other for two's-complement input, so one input stream exercises both the top-bit flip and the pass-through. The default depths put the first valid pair at edge 7. That places the zero-filled early updates, the valid rise and a reset in the middle of a stream all within a few dozen cycles. The stream starts as an incrementing index, which makes the pair order visible, and then moves to codes at and around the sign boundary.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  typedef enum logic {
    CODE_TWOS   = 1'b0,
    CODE_OFFSET = 1'b1
  } code_e;

  localparam int SDM_SMP_W   = 6;
  localparam int SDM_NEW_LAT = 5;
endpackage

// File: rtl/sdm_capture_pipe.sv
module sdm_capture_pipe
  import sdm_pkg::*;
#(
  parameter int    W       = SDM_SMP_W,
  parameter code_e CODING  = CODE_OFFSET,
  parameter int    NEW_LAT = SDM_NEW_LAT,
  localparam int   OLD_LAT = NEW_LAT + 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] smp_in,
  output logic [W-1:0] tap_new,
  output logic [W-1:0] tap_old
);
  // Coding step: flip the sign position for offset-binary input
  function automatic logic [W-1:0] to_twos(input logic [W-1:0] c);
    if (CODING == CODE_OFFSET) return {~c[W-1], c[W-2:0]};
    else                       return c;
  endfunction

  logic [W-1:0] stg [OLD_LAT];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= to_twos(smp_in);
  end

  for (genvar i = 1; i < OLD_LAT; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  // Before an edge, stage i holds the sample taken i+1 edges earlier
  assign tap_new = stg[NEW_LAT-1];
  assign tap_old = stg[OLD_LAT-1];
endmodule

// File: rtl/sdm_phase_gen.sv
module sdm_phase_gen #(
  parameter int  FILL_MAX = 6,
  localparam int CNT_W    = $clog2(FILL_MAX + 1)
) (
  input  logic clk,
  input  logic rst,
  output logic dready,
  output logic upd,
  output logic fill_done
);
  logic [CNT_W-1:0] fill_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      dready   <= 1'b0;
      fill_cnt <= '0;
    end else begin
      dready <= ~dready;
      if (fill_cnt != CNT_W'(FILL_MAX)) fill_cnt <= fill_cnt + 1'b1;
    end
  end

  // The ports load on the edge where data-ready goes high
  assign upd       = ~dready;
  assign fill_done = (fill_cnt == CNT_W'(FILL_MAX));

  AST_DRDY_RISE: assert property (@(posedge clk) disable iff (rst)
    !dready |=> dready);  // R6
  AST_DRDY_FALL: assert property (@(posedge clk) disable iff (rst)
    dready |=> !dready);  // R6
endmodule

// File: rtl/sdm_out_reg.sv
module sdm_out_reg #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd,
  input  logic         fill_done,
  input  logic         dready,
  input  logic [W-1:0] tap_new,
  input  logic [W-1:0] tap_old,
  output logic [W-1:0] new_out,
  output logic [W-1:0] old_out,
  output logic         pair_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      new_out    <= '0;
      old_out    <= '0;
      pair_valid <= 1'b0;
    end else if (upd) begin
      new_out    <= tap_new;
      old_out    <= tap_old;
      pair_valid <= pair_valid | fill_done;
    end
  end

  AST_PORTS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !upd |=> ($stable(new_out) && $stable(old_out)));  // R7
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
    pair_valid |=> pair_valid);  // R9
  AST_VALID_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(pair_valid) |-> $rose(dready));  // R9
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (new_out == '0 && old_out == '0 && !pair_valid && !dready));  // R8
endmodule

// File: rtl/sdm_pair_demux.sv
module sdm_pair_demux
  import sdm_pkg::*;
#(
  parameter int    W       = SDM_SMP_W,
  parameter code_e CODING  = CODE_OFFSET,
  parameter int    NEW_LAT = SDM_NEW_LAT,
  localparam int   OLD_LAT = NEW_LAT + 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] smp_in,
  output logic         dready,
  output logic [W-1:0] new_out,
  output logic [W-1:0] old_out,
  output logic         pair_valid
);
  logic [W-1:0] tap_new, tap_old;
  logic         upd, fill_done;

  sdm_capture_pipe #(.W(W), .CODING(CODING), .NEW_LAT(NEW_LAT)) u_pipe (
    .clk(clk), .rst(rst), .smp_in(smp_in),
    .tap_new(tap_new), .tap_old(tap_old)
  );

  sdm_phase_gen #(.FILL_MAX(OLD_LAT)) u_phase (
    .clk(clk), .rst(rst), .dready(dready), .upd(upd), .fill_done(fill_done)
  );

  sdm_out_reg #(.W(W)) u_out (
    .clk(clk), .rst(rst), .upd(upd), .fill_done(fill_done), .dready(dready),
    .tap_new(tap_new), .tap_old(tap_old),
    .new_out(new_out), .old_out(old_out), .pair_valid(pair_valid)
  );
endmodule

// File: tb/sim_sdm_pair_demux.sv
module sim_sdm_pair_demux;
  import sdm_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst = 1'b1;
  logic [5:0] smp = '0;
  logic       dr0, dr1, val0, val1;
  logic [5:0] nw0, od0, nw1, od1;

  sdm_pair_demux #(.CODING(CODE_OFFSET)) u0 (
    .clk(clk), .rst(rst), .smp_in(smp), .dready(dr0),
    .new_out(nw0), .old_out(od0), .pair_valid(val0));
  sdm_pair_demux #(.CODING(CODE_TWOS)) u1 (
    .clk(clk), .rst(rst), .smp_in(smp), .dready(dr1),
    .new_out(nw1), .old_out(od1), .pair_valid(val1));

  localparam logic [5:0] TBL [16] = '{
    6'h00, 6'h3F, 6'h20, 6'h1F, 6'h01, 6'h3E, 6'h2A, 6'h15,
    6'h10, 6'h30, 6'h0F, 6'h21, 6'h3F, 6'h00, 6'h07, 6'h38};

  int n_chk = 0;
  int n_fail = 0;
  logic [5:0] hist [0:127];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] stim(input int k);
    if (k <= 40) return 6'(k);
    return TBL[(k - 41) % 16];
  endfunction

  // Offset-to-signed: adding half scale modulo 64 flips the sign position
  function automatic logic [5:0] exp_off(input int k);
    if (k < 1) return 6'h00;
    return hist[k] + 6'd32;
  endfunction

  function automatic logic [5:0] exp_raw(input int k);
    if (k < 1) return 6'h00;
    return hist[k];
  endfunction

  task automatic check_reset_state();
    chk(nw0 == 0 && od0 == 0, "R8 ports cleared", {nw0, od0}, 0);
    chk(nw1 == 0 && od1 == 0, "R8 ports cleared (pass-through)", {nw1, od1}, 0);
    chk(!dr0 && !dr1, "R8 R6 data-ready low", {dr0, dr1}, 0);
    chk(!val0 && !val1, "R8 R9 valid low", {val0, val1}, 0);
  endtask

  // Entered at a falling edge with reset asserted; releases it and walks n edges
  task automatic run(input int n);
    logic [5:0] pn, po;
    pn = nw0; po = od0;
    hist[0] = '0;
    smp = stim(1); hist[1] = smp;
    rst = 1'b0;
    for (int e = 1; e <= n; e++) begin
      @(posedge clk); @(negedge clk);
      chk(dr0 == e[0] && dr1 == e[0], "R6 data-ready phase", dr0, e[0]);
      if (e[0]) begin
        chk(nw0 == exp_off(e - 5), "R3 R1 newer port", nw0, exp_off(e - 5));
        chk(od0 == exp_off(e - 6), "R4 R1 older port", od0, exp_off(e - 6));
        chk(nw1 == exp_raw(e - 5), "R2 R3 newer port pass-through", nw1, exp_raw(e - 5));
        chk(od1 == exp_raw(e - 6), "R2 R4 older port pass-through", od1, exp_raw(e - 6));
        if (e >= 7 && e - 5 <= 40)
          chk(6'(nw0 - od0) == 6'd1, "R5 consecutive pair order", 6'(nw0 - od0), 1);
      end else begin
        chk(nw0 == pn && od0 == po, "R7 ports hold off the rise", {nw0, od0}, {pn, po});
      end
      chk(val0 == (e >= 7) && val1 == (e >= 7), "R9 valid flag", val0, (e >= 7));
      pn = nw0; po = od0;
      smp = stim(e + 1); hist[e + 1] = smp;
    end
  endtask

  bit finished = 1'b0;

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state();
    run(72);
    // Reset in the middle of a running stream
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check_reset_state();
    @(posedge clk); @(negedge clk);
    run(30);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule